// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block sits between an interrupt source controller and one processor. It keeps three pieces of state: the priority the processor is currently running at, a single pending slot (a source number and its priority), and a software inter-processor interrupt (IPI) request priority. A numerically lower priority wins. Offers from the source controller compete for the pending slot with the IPI. The winner drives one level interrupt line to the processor. A loser is handed back through a one-cycle reject strobe, so the source controller can retry it later.

The processor reaches the block through a command port. It can acknowledge the pending interrupt and read it, inspect the state without side effects, change its running priority, request an IPI, and signal end-of-interrupt. Outbound strobes tell the source controller when a source was rejected, when a source has finished, and when held-back sources should be offered again. Every output is registered. A command or offer presented at a clock edge shows its effect on the outputs one cycle later.

Top module: `irq_presenter`

## Requirements
- R1: The 32-bit status word carries the current processor priority in bits 31:24 and the pending source number in bits 23:0. A source field of zero means nothing is pending. `irq_out` is high exactly when the source field is non-zero.
- R2: Reset (synchronous, active high) clears the status word to 0, sets the pending priority and the IPI priority to 0xFF, and holds `irq_out` low.
- R3: An offer is rejected when its priority is not strictly below the current processor priority, or when a pending entry has a priority numerically at or below the offered one. A rejection pulses `reject_stb` for one cycle with `reject_src` equal to the offered source, one cycle after the offer, and leaves the state unchanged.
- R4: Any other offer is latched as the pending source and priority, and `irq_out` goes high. A source that was already pending is displaced and reported on `reject_src` with `reject_stb`.
- R5: Command code 0 (accept) returns the status word on `rd_word` with `rd_valid`, drops `irq_out`, and copies the pending priority into bits 31:24. It also clears the source field and sets the pending priority to 0xFF.
- R6: Command code 3 (IPI write) takes the new IPI priority from `cmd_wdata[7:0]`. If that priority is strictly below the processor priority, the IPI wins the slot unless a pending entry already has an equal or lower priority. A winning IPI rejects any pending source, loads source number 2, takes the IPI priority as the pending priority, and raises `irq_out`.
- R7: Command code 2 (priority write) takes the new priority from `cmd_wdata[7:0]`. When the new value is lower than the old one, a pending entry whose priority is at or above the new value is cleared and rejected, and `irq_out` drops. Otherwise, with nothing pending, `resend_stb` pulses and the IPI is presented if its priority is below the new value.
- R8: Command code 4 (end-of-interrupt) loads the processor priority from `cmd_wdata[31:24]` and pulses `eoi_stb` with `eoi_src` equal to `cmd_wdata[23:0]`. If nothing is pending, it also pulses `resend_stb` and presents the IPI when the IPI priority is below the restored priority.
- R9: Command code 1 (poll) returns the status word on `rd_word` and the IPI priority on `rd_ipi` with `rd_valid`, and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| offer_valid | input | 1 | An interrupt offer is present this cycle |
| offer_src | input | 24 | Offered source number (non-zero, not 2) |
| offer_prio | input | 8 | Priority of the offer |
| cmd_valid | input | 1 | A processor command is present this cycle |
| cmd_op | input | 3 | Command code: 0 accept, 1 poll, 2 priority write, 3 IPI write, 4 end-of-interrupt |
| cmd_wdata | input | 32 | Command write data |
| rd_valid | output | 1 | Read data valid (accept or poll) |
| rd_word | output | 32 | Status word read back |
| rd_ipi | output | 8 | IPI priority read back |
| irq_out | output | 1 | Interrupt line to the processor |
| reject_stb | output | 1 | One-cycle reject to the source controller |
| reject_src | output | 24 | Source being rejected |
| eoi_stb | output | 1 | One-cycle end-of-interrupt to the source controller |
| eoi_src | output | 24 | Source that finished |
| resend_stb | output | 1 | One-cycle request to offer held-back sources again |

## Verification
The assertions assume that an offer and a command never share a cycle. They also assume every offered source number is non-zero and differs from the IPI number 2, since the line-tracks-source property depends on both. The stimulus only issues an offer when no command is active. It draws offered source numbers from 16 upward, so these assumptions hold in the directed part and in the pseudo-random part.

// File: rtl/irq_presenter_pkg.sv
package irq_presenter_pkg;

    localparam int PRIO_W = 8;
    localparam int SRC_W  = 24;
    localparam int WORD_W = PRIO_W + SRC_W;
    localparam int OP_W   = 3;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [SRC_W-1:0]  src_t;

    typedef enum logic [OP_W-1:0] {
        OP_ACCEPT   = 3'd0,
        OP_POLL     = 3'd1,
        OP_SET_PRIO = 3'd2,
        OP_SET_IPI  = 3'd3,
        OP_EOI      = 3'd4
    } op_e;

    typedef struct packed {
        prio_t cur_prio;
        src_t  src;
    } status_t;

    typedef struct packed {
        status_t st;
        prio_t   pend;
        prio_t   ipi;
        logic    line;
    } core_t;

    typedef struct packed {
        logic    rd_v;
        status_t rd_word;
        prio_t   rd_ipi;
        logic    rej;
        src_t    rej_src;
        logic    eoi;
        src_t    eoi_src;
        logic    resend;
    } outb_t;

    localparam prio_t PRIO_NONE = '1;
    localparam src_t  IPI_SRC   = src_t'(2);
    localparam src_t  SRC_NONE  = '0;

    localparam core_t CORE_RST = '{st: '0, pend: PRIO_NONE, ipi: PRIO_NONE, line: 1'b0};

    // Numerically lower priority is the more favoured one.
    function automatic logic beats(prio_t a, prio_t b);
        return a < b;
    endfunction

endpackage

// File: rtl/irq_presenter_slot_arb.sv
module irq_presenter_slot_arb
    import irq_presenter_pkg::*;
(
    input  prio_t cur_prio,
    input  logic  busy,
    input  prio_t pend_prio,
    input  prio_t cand_prio,
    output logic  take,
    output logic  displace
);
    // A candidate wins the slot when it beats the running priority and
    // strictly beats whatever already sits in the slot.
    always_comb begin
        take     = beats(cand_prio, cur_prio) && !(busy && !beats(cand_prio, pend_prio));
        displace = take && busy;
    end
endmodule

// File: rtl/irq_presenter_regs.sv
module irq_presenter_regs #(
    parameter type T   = logic,
    parameter T    RST = '0
) (
    input  logic clk,
    input  logic rst,
    input  T     d,
    output T     q
);
    always_ff @(posedge clk) begin
        if (rst) q <= RST;
        else     q <= d;
    end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
    import irq_presenter_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              offer_valid,
    input  logic [SRC_W-1:0]  offer_src,
    input  logic [PRIO_W-1:0] offer_prio,
    input  logic              cmd_valid,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [WORD_W-1:0] cmd_wdata,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_word,
    output logic [PRIO_W-1:0] rd_ipi,
    output logic              irq_out,
    output logic              reject_stb,
    output logic [SRC_W-1:0]  reject_src,
    output logic              eoi_stb,
    output logic [SRC_W-1:0]  eoi_src,
    output logic              resend_stb
);
    core_t   c, n;
    outb_t   o_d, o_q;
    op_e     op;
    status_t w_st;
    prio_t   w_prio;
    logic    busy;
    prio_t   ipi_cur, ipi_cand;
    logic    off_take, off_disp, ipi_take, ipi_disp;

    assign op     = op_e'(cmd_op);
    assign w_st   = status_t'(cmd_wdata);
    assign w_prio = cmd_wdata[PRIO_W-1:0];
    assign busy   = (c.st.src != SRC_NONE);

    // IPI arbitration sees the priority that is in force after the command.
    always_comb begin
        ipi_cand = c.ipi;
        ipi_cur  = c.st.cur_prio;
        if (cmd_valid) begin
            unique case (op)
                OP_SET_IPI:  ipi_cand = w_prio;
                OP_SET_PRIO: ipi_cur  = w_prio;
                OP_EOI:      ipi_cur  = w_st.cur_prio;
                default: ;
            endcase
        end
    end

    irq_presenter_slot_arb u_offer_arb (
        .cur_prio (c.st.cur_prio),
        .busy     (busy),
        .pend_prio(c.pend),
        .cand_prio(offer_prio),
        .take     (off_take),
        .displace (off_disp)
    );

    irq_presenter_slot_arb u_ipi_arb (
        .cur_prio (ipi_cur),
        .busy     (busy),
        .pend_prio(c.pend),
        .cand_prio(ipi_cand),
        .take     (ipi_take),
        .displace (ipi_disp)
    );

    always_comb begin
        n   = c;
        o_d = '0;
        if (cmd_valid) begin
            unique case (op)
                OP_ACCEPT: begin
                    o_d.rd_v        = 1'b1;
                    o_d.rd_word     = c.st;
                    o_d.rd_ipi      = c.ipi;
                    n.line          = 1'b0;
                    n.st.cur_prio   = c.pend;
                    n.st.src        = SRC_NONE;
                    n.pend          = PRIO_NONE;
                end
                OP_POLL: begin
                    o_d.rd_v    = 1'b1;
                    o_d.rd_word = c.st;
                    o_d.rd_ipi  = c.ipi;
                end
                OP_SET_PRIO: begin
                    n.st.cur_prio = w_prio;
                    if (beats(w_prio, c.st.cur_prio)) begin
                        if (busy && !beats(c.pend, w_prio)) begin
                            o_d.rej     = 1'b1;
                            o_d.rej_src = c.st.src;
                            n.st.src    = SRC_NONE;
                            n.pend      = PRIO_NONE;
                            n.line      = 1'b0;
                        end
                    end else if (!busy) begin
                        o_d.resend = 1'b1;
                        if (ipi_take) begin
                            n.st.src = IPI_SRC;
                            n.pend   = ipi_cand;
                            n.line   = 1'b1;
                        end
                    end
                end
                OP_SET_IPI: begin
                    n.ipi = w_prio;
                    if (ipi_take) begin
                        if (ipi_disp) begin
                            o_d.rej     = 1'b1;
                            o_d.rej_src = c.st.src;
                        end
                        n.st.src = IPI_SRC;
                        n.pend   = ipi_cand;
                        n.line   = 1'b1;
                    end
                end
                OP_EOI: begin
                    n.st.cur_prio = w_st.cur_prio;
                    o_d.eoi       = 1'b1;
                    o_d.eoi_src   = w_st.src;
                    if (!busy) begin
                        o_d.resend = 1'b1;
                        if (ipi_take) begin
                            n.st.src = IPI_SRC;
                            n.pend   = ipi_cand;
                            n.line   = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end else if (offer_valid) begin
            if (off_take) begin
                if (off_disp) begin
                    o_d.rej     = 1'b1;
                    o_d.rej_src = c.st.src;
                end
                n.st.src = offer_src;
                n.pend   = offer_prio;
                n.line   = 1'b1;
            end else begin
                o_d.rej     = 1'b1;
                o_d.rej_src = offer_src;
            end
        end
    end

    irq_presenter_regs #(.T(core_t), .RST(CORE_RST)) u_core_q (
        .clk(clk), .rst(rst), .d(n), .q(c)
    );

    irq_presenter_regs #(.T(outb_t), .RST(outb_t'('0))) u_outb_q (
        .clk(clk), .rst(rst), .d(o_d), .q(o_q)
    );

    assign rd_valid   = o_q.rd_v;
    assign rd_word    = o_q.rd_word;
    assign rd_ipi     = o_q.rd_ipi;
    assign irq_out    = c.line;
    assign reject_stb = o_q.rej;
    assign reject_src = o_q.rej_src;
    assign eoi_stb    = o_q.eoi;
    assign eoi_src    = o_q.eoi_src;
    assign resend_stb = o_q.resend;

    AST_LINE_TRACKS_SRC: assert property (@(posedge clk) disable iff (rst)
        irq_out == (c.st.src != SRC_NONE)); // R1

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (c == CORE_RST && !irq_out && !reject_stb && !resend_stb)); // R2

    AST_LOW_OFFER_REJECTED: assert property (@(posedge clk) disable iff (rst)
        (offer_valid && !cmd_valid && !beats(offer_prio, c.st.cur_prio))
        |=> (reject_stb && reject_src == $past(offer_src) && irq_out == $past(irq_out))); // R3

    AST_ACCEPT_DROPS: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_ACCEPT)
        |=> (!irq_out && rd_valid && rd_word == $past(c.st) && c.st.src == SRC_NONE)); // R5

    AST_EOI_ECHO: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_EOI)
        |=> (eoi_stb && eoi_src == $past(cmd_wdata[SRC_W-1:0])
             && c.st.cur_prio == $past(cmd_wdata[WORD_W-1:SRC_W]))); // R8

    AST_POLL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_POLL)
        |=> (c == $past(c) && rd_valid && !reject_stb && !resend_stb && !eoi_stb)); // R9

endmodule

// File: tb/irq_presenter_tb.sv
`timescale 1ns/1ps
module irq_presenter_tb_top;

    localparam int C_ACCEPT = 0;
    localparam int C_POLL   = 1;
    localparam int C_PRIO   = 2;
    localparam int C_IPI    = 3;
    localparam int C_EOI    = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        offer_valid = 1'b0;
    logic [23:0] offer_src = '0;
    logic [7:0]  offer_prio = '0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [31:0] cmd_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_word;
    logic [7:0]  rd_ipi;
    logic        irq_out;
    logic        reject_stb;
    logic [23:0] reject_src;
    logic        eoi_stb;
    logic [23:0] eoi_src;
    logic        resend_stb;

    always #10 clk = ~clk;

    irq_presenter dut_i (
        .clk(clk), .rst(rst),
        .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
        .rd_valid(rd_valid), .rd_word(rd_word), .rd_ipi(rd_ipi),
        .irq_out(irq_out),
        .reject_stb(reject_stb), .reject_src(reject_src),
        .eoi_stb(eoi_stb), .eoi_src(eoi_src),
        .resend_stb(resend_stb)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference state
    int m_cp, m_src, m_pp, m_ipi, m_line;
    // expected registered outputs
    int e_rv, e_rd, e_ri, e_rej, e_rsrc, e_eoi, e_esrc, e_rs;

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cp = 0; m_src = 0; m_pp = 255; m_ipi = 255; m_line = 0;
    endtask

    task automatic try_ipi();
        if (m_src != 0 && m_pp <= m_ipi) return;
        if (m_src != 0) begin
            e_rej = 1; e_rsrc = m_src;
        end
        m_src = 2; m_pp = m_ipi; m_line = 1;
    endtask

    task automatic step(string tag, bit ov, int osrc, int oprio,
                        bit cv, int op, logic [31:0] wd);
        int np;
        offer_valid = ov;
        offer_src   = osrc[23:0];
        offer_prio  = oprio[7:0];
        cmd_valid   = cv;
        cmd_op      = op[2:0];
        cmd_wdata   = wd;
        e_rv = 0; e_rd = 0; e_ri = 0; e_rej = 0; e_rsrc = 0; e_eoi = 0; e_esrc = 0; e_rs = 0;
        if (cv) begin
            case (op)
                C_ACCEPT: begin
                    e_rv = 1; e_rd = (m_cp << 24) | m_src; e_ri = m_ipi;
                    m_line = 0; m_cp = m_pp; m_src = 0; m_pp = 255;
                end
                C_POLL: begin
                    e_rv = 1; e_rd = (m_cp << 24) | m_src; e_ri = m_ipi;
                end
                C_PRIO: begin
                    np = int'(wd[7:0]);
                    if (np < m_cp) begin
                        m_cp = np;
                        if (m_src != 0 && np <= m_pp) begin
                            e_rej = 1; e_rsrc = m_src;
                            m_src = 0; m_pp = 255; m_line = 0;
                        end
                    end else begin
                        m_cp = np;
                        if (m_src == 0) begin
                            e_rs = 1;
                            if (m_ipi < m_cp) try_ipi();
                        end
                    end
                end
                C_IPI: begin
                    m_ipi = int'(wd[7:0]);
                    if (m_ipi < m_cp) try_ipi();
                end
                C_EOI: begin
                    m_cp = int'(wd[31:24]);
                    e_eoi = 1; e_esrc = int'(wd[23:0]);
                    if (m_src == 0) begin
                        e_rs = 1;
                        if (m_ipi < m_cp) try_ipi();
                    end
                end
                default: ;
            endcase
        end else if (ov) begin
            if (oprio < m_cp && !(m_src != 0 && m_pp <= oprio)) begin
                if (m_src != 0) begin
                    e_rej = 1; e_rsrc = m_src;
                end
                m_src = osrc; m_pp = oprio; m_line = 1;
            end else begin
                e_rej = 1; e_rsrc = osrc;
            end
        end
        @(negedge clk);
        check(irq_out == m_line[0], tag, "line", irq_out, m_line);
        check(reject_stb == e_rej[0] && (!e_rej[0] || reject_src == e_rsrc[23:0]),
              tag, "reject", {reject_stb, reject_src}, {e_rej[0], e_rsrc[23:0]});
        check(eoi_stb == e_eoi[0] && (!e_eoi[0] || eoi_src == e_esrc[23:0]),
              tag, "eoi", {eoi_stb, eoi_src}, {e_eoi[0], e_esrc[23:0]});
        check(resend_stb == e_rs[0], tag, "resend", resend_stb, e_rs);
        check(rd_valid == e_rv[0] && (!e_rv[0] || (rd_word == e_rd && rd_ipi == e_ri[7:0])),
              tag, "read", {rd_valid, rd_word, rd_ipi}, {e_rv[0], e_rd, e_ri[7:0]});
    endtask

    task automatic offer(string tag, int s, int p);
        step(tag, 1, s, p, 0, 0, 32'h0);
    endtask

    task automatic cmd(string tag, int op, logic [31:0] wd);
        step(tag, 0, 0, 0, 1, op, wd);
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R2: reset state seen at the ports
        step("R2 idle", 0, 0, 0, 0, 0, 32'h0);
        check(irq_out == 1'b0, "R2", "line after reset", irq_out, 0);
        cmd("R2 R9 poll", C_POLL, 32'h0);
        check(rd_word == 32'h0 && rd_ipi == 8'hFF, "R2", "reset word/ipi", {rd_word, rd_ipi}, 40'h00000000FF);

        offer("R3 prio0 blocks", 16'h10, 5);
        cmd("R7 raise to FF resend", C_PRIO, 32'hFF);
        offer("R4 present", 'h10, 5);
        offer("R3 equal pending", 'h11, 5);
        offer("R4 displace", 'h12, 3);
        cmd("R9 poll", C_POLL, 32'h0);
        check(rd_word == 32'hFF000012, "R9", "poll word", rd_word, 32'hFF000012);
        cmd("R5 accept", C_ACCEPT, 32'h0);
        check(rd_word == 32'hFF000012 && !irq_out, "R5", "accept word", rd_word, 32'hFF000012);
        cmd("R5 poll after", C_POLL, 32'h0);
        check(rd_word == 32'h03000000, "R5", "prio moved", rd_word, 32'h03000000);
        cmd("R8 eoi", C_EOI, 32'hFF000012);
        cmd("R6 ipi present", C_IPI, 32'h40);
        offer("R3 worse than ipi", 'h20, 8'h50);
        offer("R4 displace ipi", 'h30, 8'h20);
        cmd("R6 ipi blocked", C_IPI, 32'h30);
        cmd("R6 ipi displaces", C_IPI, 32'h10);
        check(reject_src == 24'h30, "R6", "displaced src", reject_src, 24'h30);
        cmd("R7 lower clears", C_PRIO, 32'h10);
        cmd("R7 raise presents ipi", C_PRIO, 32'h80);
        cmd("R5 accept ipi", C_ACCEPT, 32'h0);
        check(rd_word == 32'h80000002, "R6", "ipi word", rd_word, 32'h80000002);
        cmd("R8 eoi ipi refire", C_EOI, 32'h80000002);
        cmd("R6 ipi off", C_IPI, 32'hFF);
        cmd("R5 accept", C_ACCEPT, 32'h0);
        cmd("R8 eoi idle", C_EOI, 32'hFF000002);
        cmd("R7 same prio resend", C_PRIO, 32'hFF);

        r = 32'h1234ABCD;
        for (int i = 0; i < 600; i++) begin
            int p, s, sel;
            logic [31:0] wd;
            r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
            p = r[4] ? int'(r[3:0]) : ((r[7:5] == 3'd0) ? 255 : int'(r[11:8]));
            s = 16 + int'(r[19:12]);
            sel = int'(r[23:21]);
            wd = {p[7:0], 24'(s)};
            case (sel)
                0, 1, 2: offer("R1 R3 R4 rand", s, p);
                3: cmd("R5 rand", C_ACCEPT, 32'h0);
                4: cmd("R9 rand", C_POLL, 32'h0);
                5: cmd("R7 rand", C_PRIO, 32'(p));
                6: cmd("R6 rand", C_IPI, 32'(p));
                default: cmd("R8 rand", C_EOI, wd);
            endcase
        end

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        step("R2 re-reset", 0, 0, 0, 0, 0, 32'h0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule